// File: doc/BRIEF.md
# Byte-Stream Command Frame Decoder

This block turns a stream of bytes into control register updates. Every command frame is five bytes long: an opcode byte, then a 32-bit argument sent most significant byte first. When the fifth byte arrives, the opcode picks which control register loads the argument. The registers are the tuning frequency, the sample rate, the gain and the bias delay. The gain can be written directly, or it can be chosen through a fixed table of 29 values by sending an index. Indexes past the end of the table are dropped.

A zero byte that arrives while no frame is open does not start a frame. It is a stop request: the block raises a one-cycle stop pulse. Each completed frame raises a one-cycle command strobe and carries the opcode beside it, so that the logic around the block can react to any command, including codes that load no register.

The byte input is a valid/ready port. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The decoder never applies back-pressure: `in_ready` is low only while reset is asserted, and it is held high from the first clock edge after reset is released. The sender may leave gaps of any length between bytes. Nothing times out inside a frame.

Top module: `frame_cmd_decoder`

## Requirements
- R1: A frame is five accepted bytes: the opcode, then argument bits 31:24, 23:16, 15:8 and 7:0, in that order. The byte position returns to the start after each fifth byte and on reset.
- R2: A byte of value 0x00 accepted at the start position makes `stop_pulse` high for exactly the next cycle and opens no frame. A 0x00 byte at any later position is ordinary argument data.
- R3: Opcode 0x01 loads the argument into `tune_freq`. The new value is visible in the cycle after the fifth byte is accepted.
- R4: Opcode 0x02 loads the argument into `sample_rate`, with the same timing as R3.
- R5: Opcode 0x04 loads the argument directly into `gain`, with the same timing as R3.
- R6: Opcode 0x05 loads the argument into `bias_delay`, with the same timing as R3.
- R7: Opcode 0x0d treats the full 32-bit argument as a table index. For an index below 29, `gain` loads entry N of the list 0, 9, 14, 27, 37, 77, 87, 125, 144, 157, 166, 197, 207, 229, 254, 280, 297, 328, 338, 364, 372, 386, 402, 421, 434, 439, 445, 480, 496, where entry 0 is first. For an index of 29 or more, `gain` is unchanged.
- R8: Any other nonzero opcode completes a frame normally and leaves all four registers unchanged.
- R9: `cmd_strobe` is high for exactly one cycle, the cycle after the fifth byte is accepted. In that cycle `cmd_code` holds the frame's opcode.
- R10: While reset is asserted, `in_ready` is 0 and the registers hold their reset values: `tune_freq` = 94600000, `sample_rate` = 100000, `gain` = 120, `bias_delay` = 0. A byte presented with `in_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_ready | output | 1 | The decoder takes the byte; high whenever out of reset |
| in_data | input | 8 | Stream byte |
| tune_freq | output | 32 | Tuning frequency register |
| sample_rate | output | 32 | Sample rate register |
| gain | output | 32 | Gain register |
| bias_delay | output | 32 | Bias delay register |
| cmd_strobe | output | 1 | One-cycle pulse per completed frame |
| cmd_code | output | 8 | Opcode of the frame just completed |
| stop_pulse | output | 1 | One-cycle pulse on a stop byte |

## Verification
Two situations are the hardest to reach from the ports. The first is telling a stop byte apart from a zero byte inside a frame. The second is the edge of the gain index range, where the index value 28 must load the table and the value 29 must not. An index that has its upper argument bytes set must also be dropped. The stimulus mixes random frames and random idle gaps with directed frames for these cases. Those directed frames include zero opcode-like bytes placed at argument positions, and stop bytes sent straight after a completed frame. A bench-side counter of stop pulses is compared with the number of stop bytes sent.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int BYTE_W       = 8;
  localparam int ARG_BYTES    = 4;
  localparam int GAIN_ENTRIES = 29;
  localparam int NUM_REGS     = 4;

  // Register slots inside the bank
  localparam int SLOT_TUNE = 0;
  localparam int SLOT_RATE = 1;
  localparam int SLOT_GAIN = 2;
  localparam int SLOT_BIAS = 3;

  typedef enum logic [7:0] {
    OP_TUNE = 8'h01,
    OP_RATE = 8'h02,
    OP_GAIN = 8'h04,
    OP_BIAS = 8'h05,
    OP_GIDX = 8'h0d
  } opcode_e;

  // Gain step table, index in, step value out
  function automatic logic [15:0] gain_step(input int idx);
    logic [15:0] v;
    case (idx)
      0:  v = 16'd0;
      1:  v = 16'd9;
      2:  v = 16'd14;
      3:  v = 16'd27;
      4:  v = 16'd37;
      5:  v = 16'd77;
      6:  v = 16'd87;
      7:  v = 16'd125;
      8:  v = 16'd144;
      9:  v = 16'd157;
      10: v = 16'd166;
      11: v = 16'd197;
      12: v = 16'd207;
      13: v = 16'd229;
      14: v = 16'd254;
      15: v = 16'd280;
      16: v = 16'd297;
      17: v = 16'd328;
      18: v = 16'd338;
      19: v = 16'd364;
      20: v = 16'd372;
      21: v = 16'd386;
      22: v = 16'd402;
      23: v = 16'd421;
      24: v = 16'd434;
      25: v = 16'd439;
      26: v = 16'd445;
      27: v = 16'd480;
      28: v = 16'd496;
      default: v = 16'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/fcd_framer.sv
module fcd_framer #(
  parameter int BYTE_W    = fcd_pkg::BYTE_W,
  parameter int ARG_BYTES = fcd_pkg::ARG_BYTES,
  localparam int FRAME_BYTES = ARG_BYTES + 1,
  localparam int POS_W       = $clog2(FRAME_BYTES),
  localparam int ARG_W       = BYTE_W * ARG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              frame_fire,
  output logic [BYTE_W-1:0] frame_op,
  output logic [ARG_W-1:0]  frame_arg,
  output logic              stop_fire
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);

  logic [POS_W-1:0]        pos_q;
  logic [BYTE_W-1:0]       op_q;
  logic [ARG_W-BYTE_W-1:0] head_q;   // argument bytes seen so far
  logic                    at_start;
  logic                    at_last;

  assign at_start = (pos_q == '0);
  assign at_last  = (pos_q == LAST_POS);

  assign stop_fire  = beat && at_start && (byte_in == '0);
  assign frame_fire = beat && at_last;
  assign frame_op   = op_q;
  assign frame_arg  = {head_q, byte_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      op_q   <= '0;
      head_q <= '0;
    end else if (beat && !stop_fire) begin
      if (at_start) begin
        op_q <= byte_in;
      end else begin
        head_q <= {head_q[ARG_W-2*BYTE_W-1:0], byte_in};
      end
      pos_q <= at_last ? '0 : pos_q + POS_W'(1);
    end
  end

  a_r1_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);

  a_r1_wrap_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fire |=> (pos_q == '0));

  a_r2_stop_opens_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fire |=> (pos_q == '0));

  a_r2_stop_not_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_fire && frame_fire));

endmodule

// File: rtl/fcd_gain_lut.sv
module fcd_gain_lut #(
  parameter int ARG_W   = fcd_pkg::BYTE_W * fcd_pkg::ARG_BYTES,
  parameter int ENTRIES = fcd_pkg::GAIN_ENTRIES,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ARG_W-1:0] idx,
  output logic             hit,
  output logic [ARG_W-1:0] value
);

  logic [15:0] step;

  assign hit   = (idx < ARG_W'(ENTRIES));
  assign step  = fcd_pkg::gain_step(int'(idx[IDX_W-1:0]));
  assign value = hit ? ARG_W'(step) : '0;

  always_comb begin
    a_r7_miss_gives_zero: assert (hit || value == '0);
  end

endmodule

// File: rtl/fcd_reg_bank.sv
module fcd_reg_bank #(
  parameter int ARG_W   = fcd_pkg::BYTE_W * fcd_pkg::ARG_BYTES,
  parameter int OP_W    = fcd_pkg::BYTE_W,
  parameter logic [ARG_W-1:0] RST_TUNE = ARG_W'(94600000),
  parameter logic [ARG_W-1:0] RST_RATE = ARG_W'(100000),
  parameter logic [ARG_W-1:0] RST_GAIN = ARG_W'(120),
  parameter logic [ARG_W-1:0] RST_BIAS = '0,
  localparam int NREG = fcd_pkg::NUM_REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_fire,
  input  logic [OP_W-1:0]  frame_op,
  input  logic [ARG_W-1:0] frame_arg,
  input  logic             idx_hit,
  input  logic [ARG_W-1:0] idx_value,
  output logic [ARG_W-1:0] tune_q,
  output logic [ARG_W-1:0] rate_q,
  output logic [ARG_W-1:0] gain_q,
  output logic [ARG_W-1:0] bias_q
);

  import fcd_pkg::*;

  localparam logic [NREG*ARG_W-1:0] RST_PACK = {RST_BIAS, RST_GAIN, RST_RATE, RST_TUNE};

  logic [NREG-1:0]  we;
  logic [ARG_W-1:0] wd    [NREG];
  logic [ARG_W-1:0] reg_q [NREG];
  logic             known_op;

  always_comb begin
    we = '0;
    for (int i = 0; i < NREG; i++) wd[i] = frame_arg;
    we[SLOT_TUNE] = frame_fire && (frame_op == OP_TUNE);
    we[SLOT_RATE] = frame_fire && (frame_op == OP_RATE);
    we[SLOT_BIAS] = frame_fire && (frame_op == OP_BIAS);
    we[SLOT_GAIN] = frame_fire && ((frame_op == OP_GAIN) ||
                                   ((frame_op == OP_GIDX) && idx_hit));
    if (frame_op == OP_GIDX) wd[SLOT_GAIN] = idx_value;
  end

  assign known_op = (frame_op == OP_TUNE) || (frame_op == OP_RATE) ||
                    (frame_op == OP_GAIN) || (frame_op == OP_BIAS) ||
                    (frame_op == OP_GIDX);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     reg_q[g] <= RST_PACK[g*ARG_W +: ARG_W];
      else if (we[g]) reg_q[g] <= wd[g];
    end
  end

  assign tune_q = reg_q[SLOT_TUNE];
  assign rate_q = reg_q[SLOT_RATE];
  assign gain_q = reg_q[SLOT_GAIN];
  assign bias_q = reg_q[SLOT_BIAS];

  a_r3_tune_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fire && frame_op == OP_TUNE) |=> (tune_q == $past(frame_arg)));

  a_r4_rate_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fire && frame_op == OP_RATE) |=> (rate_q == $past(frame_arg)));

  a_r5_gain_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fire && frame_op == OP_GAIN) |=> (gain_q == $past(frame_arg)));

  a_r6_bias_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fire && frame_op == OP_BIAS) |=> (bias_q == $past(frame_arg)));

  a_r7_index_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fire && frame_op == OP_GIDX && frame_arg >= ARG_W'(GAIN_ENTRIES))
      |=> $stable(gain_q));

  a_r8_unknown_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fire && !known_op)
      |=> ($stable(tune_q) && $stable(rate_q) && $stable(gain_q) && $stable(bias_q)));

  a_r10_idle_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_fire
      |=> ($stable(tune_q) && $stable(rate_q) && $stable(gain_q) && $stable(bias_q)));

endmodule

// File: rtl/frame_cmd_decoder.sv
module frame_cmd_decoder #(
  parameter int BYTE_W       = fcd_pkg::BYTE_W,
  parameter int ARG_BYTES    = fcd_pkg::ARG_BYTES,
  parameter int GAIN_ENTRIES = fcd_pkg::GAIN_ENTRIES,
  localparam int ARG_W       = BYTE_W * ARG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic [ARG_W-1:0]  tune_freq,
  output logic [ARG_W-1:0]  sample_rate,
  output logic [ARG_W-1:0]  gain,
  output logic [ARG_W-1:0]  bias_delay,
  output logic              cmd_strobe,
  output logic [BYTE_W-1:0] cmd_code,
  output logic              stop_pulse
);

  logic              ready_q;
  logic              beat;
  logic              frame_fire;
  logic              stop_fire;
  logic [BYTE_W-1:0] frame_op;
  logic [ARG_W-1:0]  frame_arg;
  logic              idx_hit;
  logic [ARG_W-1:0]  idx_value;
  logic              strobe_q;
  logic              stop_q;
  logic [BYTE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign beat     = in_valid && ready_q;

  fcd_framer #(.BYTE_W(BYTE_W), .ARG_BYTES(ARG_BYTES)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .byte_in    (in_data),
    .frame_fire (frame_fire),
    .frame_op   (frame_op),
    .frame_arg  (frame_arg),
    .stop_fire  (stop_fire)
  );

  fcd_gain_lut #(.ARG_W(ARG_W), .ENTRIES(GAIN_ENTRIES)) u_lut (
    .idx   (frame_arg),
    .hit   (idx_hit),
    .value (idx_value)
  );

  fcd_reg_bank #(.ARG_W(ARG_W), .OP_W(BYTE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_fire (frame_fire),
    .frame_op   (frame_op),
    .frame_arg  (frame_arg),
    .idx_hit    (idx_hit),
    .idx_value  (idx_value),
    .tune_q     (tune_freq),
    .rate_q     (sample_rate),
    .gain_q     (gain),
    .bias_q     (bias_delay)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      stop_q   <= 1'b0;
      code_q   <= '0;
    end else begin
      strobe_q <= frame_fire;
      stop_q   <= stop_fire;
      if (frame_fire) code_q <= frame_op;
    end
  end

  assign cmd_strobe = strobe_q;
  assign cmd_code   = code_q;
  assign stop_pulse = stop_q;

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  a_r9_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> (cmd_code != '0));

  a_r2_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse);

  a_r10_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

endmodule

// File: tb/tb_frame_cmd_decoder.sv
module tb_frame_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [31:0] tune_freq, sample_rate, gain, bias_delay;
  logic        cmd_strobe, stop_pulse;
  logic [7:0]  cmd_code;

  int checks = 0;
  int errors = 0;
  int stops_sent = 0;
  int stops_seen = 0;
  bit done = 1'b0;

  logic [31:0] m_tune = 32'd94600000;
  logic [31:0] m_rate = 32'd100000;
  logic [31:0] m_gain = 32'd120;
  logic [31:0] m_bias = 32'd0;

  always #5 clk = ~clk;

  frame_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tune_freq(tune_freq), .sample_rate(sample_rate),
    .gain(gain), .bias_delay(bias_delay), .cmd_strobe(cmd_strobe),
    .cmd_code(cmd_code), .stop_pulse(stop_pulse)
  );

  always @(negedge clk) if (rst_n && stop_pulse) stops_seen++;

  function automatic logic [31:0] table_ref(input int i);
    int t [29] = '{0, 9, 14, 27, 37, 77, 87, 125, 144, 157, 166, 197, 207,
                   229, 254, 280, 297, 328, 338, 364, 372, 386, 402, 421,
                   434, 439, 445, 480, 496};
    return 32'(t[i]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input int gap);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'($urandom);   // R10: ignored while valid is low
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic model_apply(input logic [7:0] op, input logic [31:0] arg);
    case (op)
      8'h01: m_tune = arg;
      8'h02: m_rate = arg;
      8'h04: m_gain = arg;
      8'h05: m_bias = arg;
      8'h0d: if (arg < 32'd29) m_gain = table_ref(int'(arg));
      default: ;
    endcase
  endtask

  task automatic check_regs(input string req);
    chk({req, " tune_freq"},   tune_freq,   m_tune);
    chk({req, " sample_rate"}, sample_rate, m_rate);
    chk({req, " gain"},        gain,        m_gain);
    chk({req, " bias_delay"},  bias_delay,  m_bias);
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [31:0] arg,
                            input int maxgap, input string req);
    put_byte(op, $urandom_range(maxgap));
    for (int k = 3; k >= 0; k--) put_byte(arg[8*k +: 8], $urandom_range(maxgap));
    @(negedge clk);
    in_valid = 1'b0;
    model_apply(op, arg);
    chk("R9 strobe after fifth byte", 32'(cmd_strobe), 32'd1);
    chk("R9 cmd_code", 32'(cmd_code), 32'(op));
    chk("R2 no stop on frame", 32'(stop_pulse), 32'd0);
    check_regs(req);
    @(negedge clk);
    chk("R9 strobe one cycle", 32'(cmd_strobe), 32'd0);
  endtask

  task automatic send_stop(input int gap);
    put_byte(8'h00, gap);
    @(negedge clk);
    in_valid = 1'b0;
    stops_sent++;
    chk("R2 stop pulse", 32'(stop_pulse), 32'd1);
    chk("R2 stop is not a frame", 32'(cmd_strobe), 32'd0);
    @(negedge clk);
    chk("R2 stop one cycle", 32'(stop_pulse), 32'd0);
    check_regs("R2 stop keeps regs");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  op;
    logic [31:0] arg;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    chk("R10 ready low in reset", 32'(in_ready), 32'd0);
    check_regs("R10 reset values");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", 32'(in_ready), 32'd1);
    repeat (4) begin
      @(negedge clk); in_valid = 1'b0; in_data = 8'($urandom);
    end
    check_regs("R10 idle bytes ignored");

    // Directed cases
    send_frame(8'h01, 32'h01020304, 0, "R1 R3 byte order");
    send_frame(8'h02, 32'h00000000, 0, "R2 R4 zero bytes are data");
    send_frame(8'h04, 32'hdeadbeef, 2, "R5 direct gain");
    send_frame(8'h05, 32'h00000200, 1, "R6 bias");
    send_frame(8'h0d, 32'd28, 0, "R7 last index");
    send_frame(8'h0d, 32'd0, 0, "R7 first index");
    send_frame(8'h0d, 32'd29, 0, "R7 index 29 ignored");
    send_frame(8'h0d, 32'h01000003, 0, "R7 large index ignored");
    send_frame(8'h03, 32'hffffffff, 0, "R8 unknown code");
    send_frame(8'hff, 32'h12345678, 3, "R8 unknown code ff");
    send_stop(0);
    send_stop(2);
    send_frame(8'h01, 32'h00000000, 0, "R1 frame after stop");
    // Back-to-back frame and stop with no gap
    put_byte(8'h02, 0); put_byte(8'h00, 0); put_byte(8'h00, 0);
    put_byte(8'h00, 0); put_byte(8'h07, 0); put_byte(8'h00, 0);
    @(negedge clk); in_valid = 1'b0;
    m_rate = 32'h00000007;
    stops_sent++;
    chk("R2 stop right after frame", 32'(stop_pulse), 32'd1);
    check_regs("R1 R4 back-to-back frame");
    for (int i = 0; i < 28; i++)
      send_frame(8'h0d, 32'(i), 0, "R7 table sweep");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(9);
      case (sel)
        0: op = 8'h01;
        1: op = 8'h02;
        2: op = 8'h04;
        3: op = 8'h05;
        4, 5: op = 8'h0d;
        6: op = 8'($urandom_range(255, 1));
        default: op = 8'h01;
      endcase
      arg = $urandom;
      if (op == 8'h0d && $urandom_range(3) != 0) arg = 32'($urandom_range(40));
      if (sel == 9) send_stop($urandom_range(3));
      else send_frame(op, arg, 3, "R3 R4 R5 R6 R7 R8 random");
    end

    chk("R2 stop count", 32'(stops_seen), 32'(stops_sent));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule